// File: doc/BRIEF.md
# Snooping Tag Invalidation Unit

This unit sits beside a direct-mapped, physically indexed and physically tagged cache. It keeps the cache coherent with memory while a DMA master writes to memory over the system bus. The unit holds its own duplicate of the cache's tag and valid state. Every bus write is looked up in that duplicate, so DMA traffic never competes with the processor for its tag port and never reaches the data array. When a bus write lands in a block the cache holds, the unit drops that block from both the processor's tag store and the duplicate in the same clock edge.

The processor side keeps both copies in step. A line fill writes a tag and sets the line valid, and an eviction clears it. A combinational lookup port into the processor tag store shows what the processor would see on its next access. A fill that reaches the same line in the same cycle as a snoop hit loses to the invalidation and is flagged so the cache can issue the fill again. A counter records how many invalidations have taken place.

With the default parameters the cache has 64 lines of 16 bytes and uses 32-bit addresses.

Top module: `snoop_inval_unit`

## Requirements
- R1: After reset every line is invalid in both tag copies, `invalCount` is 0, and `snoopHit`, `fillRetry` and `cpuHit` are 0.
- R2: An address is split into byte offset bits [3:0], line index bits [9:4] and tag bits [31:10]. After a fill of address A, `cpuHit` is 1 for every lookup address that has A's index and tag, whatever its offset bits are.
- R3: A bus write (`busValid`=1, `busWrite`=1) whose index selects a valid line holding the same tag raises `snoopHit` in that cycle. From the next cycle that line is invalid in both copies.
- R4: A bus write whose line is invalid, or holds a different tag, leaves `snoopHit` at 0 and changes no line and no count.
- R5: A bus read (`busWrite`=0) never raises `snoopHit` and never invalidates a line, even when its address is resident.
- R6: An invalidation clears only the matched index. Every other valid line stays valid with its tag unchanged.
- R7: `invalCount` goes up by exactly one on each clock edge where an invalidation happens, and holds otherwise.
- R8: A fill in the same cycle as a snoop hit at the same index is discarded, and `fillRetry` is 1 in that cycle. The line is invalid afterwards. A fill at a different index in a snoop-hit cycle takes effect, and `fillRetry` stays 0.
- R9: An eviction clears the line in both copies, so a later bus write to that address misses. An eviction and a fill to the same index in the same cycle leave the line invalid.
- R10: A fill to an index that already holds a different tag replaces it. After that, a bus write with the old tag misses and one with the new tag hits.
- R11: The valid bits of the processor tag store and the snoop copy are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus transaction is present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Physical address of the bus transaction |
| fillValid | input | 1 | Processor line fill request |
| fillAddr | input | ADDR_W | Physical address of the filled line |
| evictValid | input | 1 | Processor eviction request |
| evictIdx | input | IDX_W | Line index to evict |
| lookupAddr | input | ADDR_W | Address probed in the processor tag store |
| cpuHit | output | 1 | Lookup address is resident in the processor tag store |
| snoopHit | output | 1 | The current bus write hits a resident line |
| fillRetry | output | 1 | The current fill was discarded by a same-index invalidation |
| invalCount | output | CNT_W | Invalidations performed since reset (wraps) |

## Verification
The in-RTL assertions check four things on every cycle. The two valid copies stay equal. A read never invalidates. A retry only ever comes with an invalidation that blocks the fill. The counter moves only on an invalidation, and the matched line is gone on the following cycle. Other behaviour can only be shown by the bench's scenarios, which compare against a reference tag model. These cover offset-independent hits, the invalidation leaving neighbouring lines alone, replacement of an old tag, the outcome of fill, evict and snoop collisions, and the exact count value.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  // Strobes issued by the control block to the tag datapath each cycle.
  typedef struct packed {
    logic invalEn;   // clear the line selected by the bus address
    logic fillEn;    // write fill tag and set valid
    logic evictEn;   // clear the line selected by the eviction index
    logic fillDrop;  // fill discarded this cycle (collision with invalidation)
  } snoopStrobes_t;

endpackage

// File: rtl/snoop_tag_store.sv
module snoop_tag_store #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setEn,
  input  logic [IDX_W-1:0] setIdx,
  input  logic [TAG_W-1:0] setTag,
  input  logic             clrAEn,
  input  logic [IDX_W-1:0] clrAIdx,
  input  logic             clrBEn,
  input  logic [IDX_W-1:0] clrBIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [TAG_W-1:0] rdTag,
  output logic             rdValid,
  output logic [LINES-1:0] validVec
);

  logic [TAG_W-1:0] tagMem [LINES];
  logic [LINES-1:0] validQ;

  // Clears always win over a set of the same line.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if ((clrAEn && clrAIdx == IDX_W'(i)) || (clrBEn && clrBIdx == IDX_W'(i))) begin
          validQ[i] <= 1'b0;
        end else if (setEn && setIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (setEn) begin
      tagMem[setIdx] <= setTag;
    end
  end

  assign rdTag    = tagMem[rdIdx];
  assign rdValid  = validQ[rdIdx];
  assign validVec = validQ;

  AST_CLEAR_A_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrAEn |=> !validQ[$past(clrAIdx)]) else $error("clear A ignored"); // R3
  AST_CLEAR_B_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrBEn |=> !validQ[$past(clrBIdx)]) else $error("clear B ignored"); // R9

endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic          snoopMatch,
  input  logic          fillValid,
  input  logic          fillSameIdx,
  input  logic          evictValid,
  output snoopStrobes_t strb
);

  logic writeSeen;
  logic invalNow;
  logic clash;

  always_comb begin
    writeSeen = busValid && busWrite;
    invalNow  = writeSeen && snoopMatch;
    clash     = invalNow && fillValid && fillSameIdx;
    strb.invalEn  = invalNow;
    strb.fillDrop = clash;
    strb.fillEn   = fillValid && !clash;
    strb.evictEn  = evictValid;
  end

  AST_READ_NO_INVAL: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> !strb.invalEn) else $error("read invalidated"); // R5
  AST_DROP_NEEDS_INVAL: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillDrop |-> (strb.invalEn && !strb.fillEn)) else $error("bad drop"); // R8

endmodule

// File: rtl/snoop_tag_dp.sv
module snoop_tag_dp
  import snoop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  snoopStrobes_t     strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [IDX_W-1:0]  evictIdx,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              snoopMatch,
  output logic              fillSameIdx,
  output logic              cpuHit,
  output logic [CNT_W-1:0]  invalCount
);

  logic [IDX_W-1:0] busIdx, fillIdx, lookIdx;
  logic [TAG_W-1:0] busTag, fillTag, lookTag;
  logic [TAG_W-1:0] snpRdTag, cpuRdTag;
  logic             snpRdValid, cpuRdValid;
  logic [LINES-1:0] snpValidVec, cpuValidVec;
  logic [3*OFF_W-1:0] unusedOffsets;

  assign busIdx  = busAddr[OFF_W +: IDX_W];
  assign busTag  = busAddr[ADDR_W-1 -: TAG_W];
  assign fillIdx = fillAddr[OFF_W +: IDX_W];
  assign fillTag = fillAddr[ADDR_W-1 -: TAG_W];
  assign lookIdx = lookupAddr[OFF_W +: IDX_W];
  assign lookTag = lookupAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffsets = {busAddr[OFF_W-1:0], fillAddr[OFF_W-1:0], lookupAddr[OFF_W-1:0]};

  // Duplicate tag copy: read port serves the bus snoop only.
  snoop_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoopCopy (
    .clk(clk), .rstN(rstN),
    .setEn(strb.fillEn), .setIdx(fillIdx), .setTag(fillTag),
    .clrAEn(strb.invalEn), .clrAIdx(busIdx),
    .clrBEn(strb.evictEn), .clrBIdx(evictIdx),
    .rdIdx(busIdx), .rdTag(snpRdTag), .rdValid(snpRdValid),
    .validVec(snpValidVec)
  );

  // Processor tag store: read port serves processor lookups only.
  snoop_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_cpuTags (
    .clk(clk), .rstN(rstN),
    .setEn(strb.fillEn), .setIdx(fillIdx), .setTag(fillTag),
    .clrAEn(strb.invalEn), .clrAIdx(busIdx),
    .clrBEn(strb.evictEn), .clrBIdx(evictIdx),
    .rdIdx(lookIdx), .rdTag(cpuRdTag), .rdValid(cpuRdValid),
    .validVec(cpuValidVec)
  );

  assign snoopMatch  = snpRdValid && (snpRdTag == busTag);
  assign fillSameIdx = (fillIdx == busIdx);
  assign cpuHit      = cpuRdValid && (cpuRdTag == lookTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invalCount <= '0;
    end else if (strb.invalEn) begin
      invalCount <= invalCount + CNT_W'(1);
    end
  end

  AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    cpuValidVec == snpValidVec) else $error("tag copies diverge"); // R11
  AST_COUNT_ONLY_ON_INVAL: assert property (@(posedge clk) disable iff (!rstN)
    (invalCount != $past(invalCount)) |-> $past(strb.invalEn)) else $error("stray count"); // R7
  AST_INVAL_CLEARS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    strb.invalEn |=> !cpuValidVec[$past(busIdx)]) else $error("cpu line kept"); // R3

endmodule

// File: rtl/snoop_inval_unit.sv
module snoop_inval_unit
  import snoop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              evictValid,
  input  logic [IDX_W-1:0]  evictIdx,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              cpuHit,
  output logic              snoopHit,
  output logic              fillRetry,
  output logic [CNT_W-1:0]  invalCount
);

  snoopStrobes_t strb;
  logic          snoopMatch;
  logic          fillSameIdx;

  snoop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite),
    .snoopMatch(snoopMatch),
    .fillValid(fillValid), .fillSameIdx(fillSameIdx),
    .evictValid(evictValid),
    .strb(strb)
  );

  snoop_tag_dp #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busAddr(busAddr), .fillAddr(fillAddr), .evictIdx(evictIdx),
    .lookupAddr(lookupAddr),
    .snoopMatch(snoopMatch), .fillSameIdx(fillSameIdx),
    .cpuHit(cpuHit), .invalCount(invalCount)
  );

  assign snoopHit  = strb.invalEn;
  assign fillRetry = strb.fillDrop;

endmodule

// File: tb/snoop_inval_unit_tb.sv
`timescale 1ns/1ps
module snoop_inval_unit_tb;

  localparam int ADDR_W = 32;
  localparam int LINES  = 64;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 6;
  localparam int TAG_W  = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busWrite = 0, fillValid = 0, evictValid = 0;
  logic [ADDR_W-1:0] busAddr = '0, fillAddr = '0, lookupAddr = '0;
  logic [IDX_W-1:0] evictIdx = '0;
  logic cpuHit, snoopHit, fillRetry;
  logic [CNT_W-1:0] invalCount;

  int checks = 0;
  int errors = 0;

  logic             refValid [LINES];
  logic [TAG_W-1:0] refTag   [LINES];
  int               refCount = 0;

  always #2.5 clk = ~clk;

  snoop_inval_unit u_dut (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .evictValid(evictValid), .evictIdx(evictIdx),
    .lookupAddr(lookupAddr),
    .cpuHit(cpuHit), .snoopHit(snoopHit), .fillRetry(fillRetry),
    .invalCount(invalCount)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(input int tag, input int idx, input int off);
    return {TAG_W'(tag), IDX_W'(idx), 4'(off)};
  endfunction

  function automatic int idxOf(input logic [ADDR_W-1:0] a);
    return int'(a[9:4]);
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(input logic [ADDR_W-1:0] a);
    return a[31:10];
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check combinational outputs and the
  // registered count, then advance the reference model across the next edge.
  task automatic step(input string req,
                      input logic bv, input logic bw, input logic [ADDR_W-1:0] ba,
                      input logic fv, input logic [ADDR_W-1:0] fa,
                      input logic ev, input int ei,
                      input logic [ADDR_W-1:0] la);
    logic expHit, expRetry, expCpu;
    int bi, fi, li;
    @(negedge clk);
    busValid = bv; busWrite = bw; busAddr = ba;
    fillValid = fv; fillAddr = fa;
    evictValid = ev; evictIdx = IDX_W'(ei);
    lookupAddr = la;
    #1;
    bi = idxOf(ba); fi = idxOf(fa); li = idxOf(la);
    expHit   = bv && bw && refValid[bi] && refTag[bi] == tagOf(ba);
    expRetry = fv && expHit && (fi == bi);
    expCpu   = refValid[li] && refTag[li] == tagOf(la);
    check(req, "snoopHit", snoopHit, expHit);
    check(req, "fillRetry", fillRetry, expRetry);
    check(req, "cpuHit", cpuHit, expCpu);
    check(req, "invalCount", invalCount, refCount);
    if (expHit) begin refValid[bi] = 1'b0; refCount = (refCount + 1) % 65536; end
    if (ev) refValid[ei] = 1'b0;
    if (fv && !expRetry && !(ev && ei == fi)) begin
      refValid[fi] = 1'b1; refTag[fi] = tagOf(fa);
    end
  endtask

  task automatic idle(input string req, input logic [ADDR_W-1:0] la);
    step(req, 0, 0, '0, 0, '0, 0, 0, la);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < LINES; i++) begin refValid[i] = 0; refTag[i] = '0; end
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk); #1;
    check("R1", "invalCount", invalCount, 0);
    check("R1", "cpuHit", cpuHit, 0);
    check("R1", "snoopHit", snoopHit, 0);
    rstN = 1'b1;
    // R1: a bus write right after reset misses everywhere
    step("R1", 1, 1, mkAddr(0, 0, 0), 0, '0, 0, 0, mkAddr(0, 0, 0));

    // R2: fill then look up at several offsets
    step("R2", 0, 0, '0, 1, mkAddr(5, 3, 0), 0, 0, '0);
    idle("R2", mkAddr(5, 3, 0));
    idle("R2", mkAddr(5, 3, 15));
    idle("R2", mkAddr(6, 3, 7));
    step("R2", 0, 0, '0, 1, mkAddr(9, 4, 0), 0, 0, '0);
    step("R2", 0, 0, '0, 1, mkAddr(11, 5, 0), 0, 0, '0);

    // R5: read of a resident address has no effect
    step("R5", 1, 0, mkAddr(5, 3, 8), 0, '0, 0, 0, mkAddr(5, 3, 0));
    idle("R5", mkAddr(5, 3, 0));
    // R4: write with wrong tag and to an invalid line
    step("R4", 1, 1, mkAddr(7, 3, 0), 0, '0, 0, 0, mkAddr(5, 3, 0));
    step("R4", 1, 1, mkAddr(5, 20, 0), 0, '0, 0, 0, mkAddr(5, 3, 0));
    idle("R4", mkAddr(5, 3, 0));
    // R3: matching write invalidates; R6: neighbours unaffected
    step("R3", 1, 1, mkAddr(5, 3, 12), 0, '0, 0, 0, mkAddr(5, 3, 0));
    idle("R3", mkAddr(5, 3, 0));
    step("R3", 1, 1, mkAddr(5, 3, 0), 0, '0, 0, 0, mkAddr(9, 4, 0));
    idle("R6", mkAddr(9, 4, 0));
    idle("R6", mkAddr(11, 5, 0));
    // R7: count after one hit
    idle("R7", '0);

    // R8: fill colliding with a snoop hit at the same index
    step("R8", 1, 1, mkAddr(9, 4, 0), 1, mkAddr(30, 4, 0), 0, 0, '0);
    idle("R8", mkAddr(30, 4, 0));
    idle("R8", mkAddr(9, 4, 0));
    // R8: fill at a different index during a snoop hit
    step("R8", 1, 1, mkAddr(11, 5, 0), 1, mkAddr(31, 6, 0), 0, 0, '0);
    idle("R8", mkAddr(31, 6, 0));
    idle("R7", mkAddr(11, 5, 0));

    // R9: eviction then bus write misses
    step("R9", 0, 0, '0, 0, '0, 1, 6, mkAddr(31, 6, 0));
    step("R9", 1, 1, mkAddr(31, 6, 0), 0, '0, 0, 0, mkAddr(31, 6, 0));
    // R9: eviction and fill same index same cycle
    step("R9", 0, 0, '0, 1, mkAddr(2, 7, 0), 1, 7, '0);
    idle("R9", mkAddr(2, 7, 0));

    // R10: replacement
    step("R10", 0, 0, '0, 1, mkAddr(1, 8, 0), 0, 0, '0);
    step("R10", 0, 0, '0, 1, mkAddr(2, 8, 0), 0, 0, '0);
    step("R10", 1, 1, mkAddr(1, 8, 0), 0, '0, 0, 0, mkAddr(2, 8, 0));
    step("R10", 1, 1, mkAddr(2, 8, 4), 0, '0, 0, 0, mkAddr(2, 8, 0));
    idle("R10", mkAddr(2, 8, 0));

    // Random mix over a small tag/index pool so hits and collisions occur.
    for (int n = 0; n < 4000; n++) begin
      logic bv, bw, fv, ev;
      bv = ($urandom % 4) != 0;
      bw = ($urandom % 3) != 0;
      fv = ($urandom % 3) == 0;
      ev = ($urandom % 8) == 0;
      step("random R3 R4 R8",
           bv, bw, mkAddr($urandom % 3, $urandom % 8, $urandom % 16),
           fv, mkAddr($urandom % 3, $urandom % 8, $urandom % 16),
           ev, $urandom % 8,
           mkAddr($urandom % 3, $urandom % 8, $urandom % 16));
    end
    idle("R7", '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule